// File: doc/BRIEF.md
# Carry-Flag Integer ALU

This block is a clocked integer arithmetic unit that keeps one persistent carry flag. Each request presents an opcode, two operands and a valid strobe. One clock edge later the block shows the registered result and the updated carry, together with a single-cycle done pulse. The carry survives from one request to the next. This lets multi-word arithmetic and bit-serial shifting be chained: add-with-carry, subtract-with-borrow and the two rotates through carry all consume the flag left by the previous operation.

Unary operations (shifts, rotates, increment, decrement) act on operand A and ignore operand B. Subtraction uses borrow semantics: the flag is 1 when the unsigned subtraction wrapped below zero. A synchronous reset clears the flag and the output registers.

Top module: `carry_alu`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the result, the carry and done are all cleared to zero, even if carry was 1.
- R2: A request sampled with `valid` high at a clock edge updates `result` and `carry` and raises `done` at that same edge. `done` is high for exactly one cycle per request. With `valid` low, `result` and `carry` hold, whatever the opcode and operands do.
- R3: Increment (opcode 5) returns A+1 modulo 2^WIDTH. It sets carry to 1 only when A is all ones, and clears it otherwise. B has no effect.
- R4: Decrement (opcode 6) returns A-1 modulo 2^WIDTH. It sets carry to 1 only when A is zero, and clears it otherwise.
- R5: Arithmetic shift right (opcode 0) shifts A right by one bit, keeps the original MSB in the MSB, and moves bit 0 into carry.
- R6: Shift left (opcode 1) moves the MSB of A into carry and fills bit 0 with zero. Shift right (opcode 2) moves bit 0 into carry and fills the MSB with zero.
- R7: Rotate left through carry (opcode 3) puts the old carry in bit 0 and the old MSB into carry. Rotate right through carry (opcode 4) puts the old carry in the MSB and the old bit 0 into carry.
- R8: Add (opcode 7) returns A+B, and add-with-carry (opcode 9) returns A+B+carry. Both set carry to the unsigned carry out of the MSB.
- R9: Subtract (opcode 8) returns A-B and sets carry to 1 exactly when A < B as unsigned values.
- R10: Subtract-with-borrow (opcode 10) returns A-B-carry. The new carry is (A <= B) when the incoming carry is 1, and (A < B) when it is 0.
- R11: Opcodes 11 to 15 return A as the result, leave carry unchanged, and still pulse done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| operandA | input | WIDTH | First operand; the source for unary operations |
| operandB | input | WIDTH | Second operand |
| result | output | WIDTH | Registered result |
| carry | output | 1 | Persistent carry/borrow flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default WIDTH of 32. All corner operands are therefore written as full 32-bit values: all ones for the increment wrap, zero for the decrement borrow, a lone MSB for the shifts and rotates, and equal operands for the two borrow rules. At this width a carry out of bit 31 is reachable directly, for example from 0xFFFFFFFF+1. The flag is also steered into a known state before each carry-consuming operation, so that both incoming carry values are exercised.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_SAR = 4'd0;
  localparam logic [OP_W-1:0] OPC_SHL = 4'd1;
  localparam logic [OP_W-1:0] OPC_SHR = 4'd2;
  localparam logic [OP_W-1:0] OPC_RCL = 4'd3;
  localparam logic [OP_W-1:0] OPC_RCR = 4'd4;
  localparam logic [OP_W-1:0] OPC_INC = 4'd5;
  localparam logic [OP_W-1:0] OPC_DEC = 4'd6;
  localparam logic [OP_W-1:0] OPC_ADD = 4'd7;
  localparam logic [OP_W-1:0] OPC_SUB = 4'd8;
  localparam logic [OP_W-1:0] OPC_ADC = 4'd9;
  localparam logic [OP_W-1:0] OPC_SBC = 4'd10;

  typedef enum logic [3:0] {
    K_PASS, K_SAR, K_SHL, K_SHR, K_RCL, K_RCR,
    K_INC, K_DEC, K_ADD, K_SUB, K_ADC, K_SBC
  } aluKind_e;

  typedef struct packed {
    logic     load;
    logic     carryWe;
    aluKind_e kind;
  } aluStrobes_t;

endpackage

// File: rtl/carry_alu_ctrl.sv
module carry_alu_ctrl
  import carry_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic [OP_W-1:0] op,
  output aluStrobes_t     strobes,
  output logic            doneQ
);

  aluKind_e kindDec;

  always_comb begin
    case (op)
      OPC_SAR: kindDec = K_SAR;
      OPC_SHL: kindDec = K_SHL;
      OPC_SHR: kindDec = K_SHR;
      OPC_RCL: kindDec = K_RCL;
      OPC_RCR: kindDec = K_RCR;
      OPC_INC: kindDec = K_INC;
      OPC_DEC: kindDec = K_DEC;
      OPC_ADD: kindDec = K_ADD;
      OPC_SUB: kindDec = K_SUB;
      OPC_ADC: kindDec = K_ADC;
      OPC_SBC: kindDec = K_SBC;
      default: kindDec = K_PASS;
    endcase
  end

  always_comb begin
    strobes.load    = valid;
    strobes.carryWe = valid && (kindDec != K_PASS);
    strobes.kind    = kindDec;
  end

  always_ff @(posedge clk) begin
    if (rst) doneQ <= 1'b0;
    else     doneQ <= valid;
  end

  // R2
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> doneQ);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !doneQ);

endmodule

// File: rtl/carry_alu_dp.sv
module carry_alu_dp
  import carry_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  aluStrobes_t      strobes,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] resQ,
  output logic             carryQ
);

  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH:0] ONE_EXT = {{WIDTH{1'b0}}, 1'b1};

  logic [WIDTH:0]   addExt, subExt, incExt, decExt;
  logic             cinAdd, cinSub;
  logic [WIDTH-1:0] resNext;
  logic             carryNext;

  assign cinAdd = (strobes.kind == K_ADC) ? carryQ : 1'b0;
  assign cinSub = (strobes.kind == K_SBC) ? carryQ : 1'b0;

  // Widened adders: the extra top bit carries out (add) or borrows (sub).
  assign addExt = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cinAdd};
  assign subExt = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cinSub};
  assign incExt = {1'b0, a} + ONE_EXT;
  assign decExt = {1'b0, a} - ONE_EXT;

  always_comb begin
    resNext   = a;
    carryNext = carryQ;
    case (strobes.kind)
      K_SAR: begin resNext = {a[MSB], a[MSB:1]};  carryNext = a[0];   end
      K_SHL: begin resNext = {a[MSB-1:0], 1'b0};  carryNext = a[MSB]; end
      K_SHR: begin resNext = {1'b0, a[MSB:1]};    carryNext = a[0];   end
      K_RCL: begin resNext = {a[MSB-1:0], carryQ}; carryNext = a[MSB]; end
      K_RCR: begin resNext = {carryQ, a[MSB:1]};  carryNext = a[0];   end
      K_INC: begin resNext = incExt[MSB:0]; carryNext = incExt[WIDTH]; end
      K_DEC: begin resNext = decExt[MSB:0]; carryNext = decExt[WIDTH]; end
      K_ADD, K_ADC: begin resNext = addExt[MSB:0]; carryNext = addExt[WIDTH]; end
      K_SUB, K_SBC: begin resNext = subExt[MSB:0]; carryNext = subExt[WIDTH]; end
      default: begin resNext = a; carryNext = carryQ; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resQ   <= '0;
      carryQ <= 1'b0;
    end else begin
      if (strobes.load)    resQ   <= resNext;
      if (strobes.carryWe) carryQ <= carryNext;
    end
  end

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> ($stable(resQ) && $stable(carryQ)));

  // R3
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.kind == K_INC && a == '1) |=> (carryQ && resQ == '0));

  // R9
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.kind == K_SUB) |=> (carryQ == ($past(a) < $past(b))));

  // R11
  pass_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.kind == K_PASS) |=> (resQ == $past(a) && $stable(carryQ)));

endmodule

// File: rtl/carry_alu.sv
module carry_alu
  import carry_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] operandA,
  input  logic [WIDTH-1:0] operandB,
  output logic [WIDTH-1:0] result,
  output logic             carry,
  output logic             done
);

  aluStrobes_t strobes;

  carry_alu_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .valid   (valid),
    .op      (op),
    .strobes (strobes),
    .doneQ   (done)
  );

  carry_alu_dp #(.WIDTH(WIDTH)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .a       (operandA),
    .b       (operandB),
    .resQ    (result),
    .carryQ  (carry)
  );

endmodule

// File: tb/test_carry_alu.sv
`timescale 1ns/1ps
module test_carry_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] operandA = '0;
  logic [31:0] operandB = '0;
  logic [31:0] result;
  logic        carry;
  logic        done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  carry_alu #(.WIDTH(32)) i_carry_alu (
    .clk(clk), .rst(rst), .valid(valid), .op(op),
    .operandA(operandA), .operandB(operandB),
    .result(result), .carry(carry), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Issue one request, then sample after the edge that registers it.
  task automatic runOp(input logic [3:0] code, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expRes, input logic expCy, input string tag);
    @(negedge clk);
    op = code; operandA = a; operandB = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check({tag, " result"}, result, expRes);
    check({tag, " carry"}, {31'd0, carry}, {31'd0, expCy});
    check("R2 done pulse", {31'd0, done}, 32'd1);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 32'd0);
    check("R1 reset carry", {31'd0, carry}, 32'd0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    rst = 1'b0;
    runOp(4'd5, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b1, "R3 set cy");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid reset carry", {31'd0, carry}, 32'd0);
    check("R1 mid reset result", result, 32'd0);
  endtask

  task automatic testIncDec();
    runOp(4'd5, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b1, "R3 inc wrap");
    runOp(4'd5, 32'd5, 32'hFFFF_FFFF, 32'd6, 1'b0, "R3 inc B ignored");
    runOp(4'd6, 32'd0, 32'd0, 32'hFFFF_FFFF, 1'b1, "R4 dec zero");
    runOp(4'd6, 32'd1, 32'd7, 32'd0, 1'b0, "R4 dec one");
  endtask

  task automatic testShifts();
    runOp(4'd0, 32'h8000_0003, 32'd0, 32'hC000_0001, 1'b1, "R5 sar neg");
    runOp(4'd0, 32'd4, 32'd0, 32'd2, 1'b0, "R5 sar pos");
    runOp(4'd1, 32'h8000_0001, 32'd0, 32'd2, 1'b1, "R6 shl");
    runOp(4'd2, 32'h8000_0001, 32'd0, 32'h4000_0000, 1'b1, "R6 shr");
    runOp(4'd2, 32'd2, 32'd0, 32'd1, 1'b0, "R6 shr even");
  endtask

  task automatic testRotates();
    runOp(4'd5, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b1, "R3 prep cy1");
    runOp(4'd3, 32'd0, 32'd0, 32'd1, 1'b0, "R7 rcl cin1");
    runOp(4'd3, 32'h8000_0000, 32'd0, 32'd0, 1'b1, "R7 rcl msb");
    runOp(4'd4, 32'd0, 32'd0, 32'h8000_0000, 1'b0, "R7 rcr cin1");
    runOp(4'd4, 32'd1, 32'd0, 32'd0, 1'b1, "R7 rcr lsb");
  endtask

  task automatic testAdd();
    runOp(4'd7, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1, "R8 add carry out");
    runOp(4'd7, 32'd1, 32'd2, 32'd3, 1'b0, "R8 add plain");
    runOp(4'd7, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1, "R8 prep cy1");
    runOp(4'd9, 32'd5, 32'd6, 32'd12, 1'b0, "R8 adc cin1");
    runOp(4'd9, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 1'b0, "R8 adc cin0");
    runOp(4'd7, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1, "R8 prep cy1 again");
    runOp(4'd9, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b1, "R8 adc ripple");
  endtask

  task automatic testSub();
    runOp(4'd8, 32'd3, 32'd5, 32'hFFFF_FFFE, 1'b1, "R9 sub borrow");
    runOp(4'd8, 32'd5, 32'd5, 32'd0, 1'b0, "R9 sub equal");
    runOp(4'd10, 32'd5, 32'd5, 32'd0, 1'b0, "R10 sbc eq cin0");
    runOp(4'd8, 32'd0, 32'd1, 32'hFFFF_FFFF, 1'b1, "R9 prep cy1");
    runOp(4'd10, 32'd5, 32'd5, 32'hFFFF_FFFF, 1'b1, "R10 sbc eq cin1");
    runOp(4'd10, 32'd6, 32'd5, 32'd0, 1'b0, "R10 sbc gt cin1");
  endtask

  task automatic testUnused();
    runOp(4'd8, 32'd0, 32'd1, 32'hFFFF_FFFF, 1'b1, "R9 prep cy1");
    runOp(4'd11, 32'h0000_1234, 32'd9, 32'h0000_1234, 1'b1, "R11 op11 keeps cy1");
    runOp(4'd8, 32'd5, 32'd5, 32'd0, 1'b0, "R9 prep cy0");
    runOp(4'd15, 32'h0000_ABCD, 32'hFFFF_FFFF, 32'h0000_ABCD, 1'b0, "R11 op15 keeps cy0");
  endtask

  task automatic testIdleHold();
    runOp(4'd8, 32'd0, 32'd1, 32'hFFFF_FFFF, 1'b1, "R9 prep hold");
    for (int i = 0; i < 3; i++) begin
      op = 4'd1; operandA = 32'h8000_0000 >> i; operandB = 32'd3;
      @(negedge clk);
      check("R2 idle done low", {31'd0, done}, 32'd0);
      check("R2 idle result hold", result, 32'hFFFF_FFFF);
      check("R2 idle carry hold", {31'd0, carry}, 32'd1);
    end
  endtask

  initial begin
    testReset();
    testIncDec();
    testShifts();
    testRotates();
    testAdd();
    testSub();
    testUnused();
    testIdleHold();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule